// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave with Write-Busy and Protected Range

This block is the slave end of a two-wire serial bus (a clock line and an open-drain data line) placed in front of a small byte array. The master opens a transfer with a start condition and sends an address byte. That byte holds a fixed device identifier, a group of select bits and a direction bit. If the byte matches this device, the slave acknowledges it. A write then carries one word-address byte and one data byte. A read returns bytes from the current word address for as long as the master keeps acknowledging.

A byte write is not committed when its data byte arrives. It is committed only when the master closes the transfer with a stop. That stop also starts a write-busy period of a programmable number of system clocks. For the whole of that period the slave does not respond on the bus and keeps the data line released. Data bytes aimed at an address inside a configured protected window are not acknowledged and leave the array unchanged.

Both bus lines are sampled by the system clock through a two-stage synchroniser. Start and stop conditions are recognised as data-line edges while the clock line is high. The data output is a pull-low enable that the pad turns into an open-drain drive.

Top module: `twoWireMemSlave`

## Requirements
- R1: The slave changes its data-line drive only in the system cycle after it detects a bus-clock falling edge, a start or a stop. It acknowledges a byte by pulling the line low for the whole ninth bus clock.
- R2: An address byte is acknowledged only when bits 7:4 equal the identifier parameter (default 4'b1010) and bits 3:1 equal the `selPins` input. Otherwise the slave stays released for all further bytes until the next start or stop.
- R3: In a write transfer, the word-address byte and a data byte to an unprotected address are both acknowledged.
- R4: A byte write is an address byte with bit 0 = 0, a word-address byte whose low ADDR_W bits select the word, one data byte and a stop. After the busy period, a read of that word returns the data.
- R5: The array is written only by a stop that follows an acknowledged data byte. A repeated start before that stop abandons the write.
- R6: For BUSY_CYCLES system clocks after a write's stop, the slave ignores every bus event, acknowledges nothing and keeps the data line released.
- R7: An address byte with bit 0 = 1 starts a read. The slave sends the byte at the current word address, most significant bit first. It sends further bytes while the master acknowledges at the ninth clock.
- R8: When the master does not acknowledge a read byte, the slave releases the line and stays silent until a start or stop.
- R9: A data byte whose word address lies in PROT_LO..PROT_HI inclusive is not acknowledged, and that word keeps its old value.
- R10: The word address advances by one after each byte sent and wraps from 2**ADDR_W-1 to 0.
- R11: A stop at any point outside the busy period returns the slave to idle. A start at any point outside it restarts address decoding, and the word address is kept.
- R12: After reset the data line is released and every array word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| selPins | input | 3 | Strapped select value compared with address bits 3:1 |
| sdaDriveLow | output | 1 | 1 pulls the data line low; 0 releases it |

## Verification
A new start and address byte can arrive while the write-busy period started by the previous stop is still counting. The bench provokes this by sending a matching address byte straight after a write's stop. It then checks that no acknowledge appears, and that the data line stays released on every system clock of the window. The second overlap is a start or stop inside a byte or before a pending commit. The bench judges it by reading back the array: the word must still hold its old value after an abandoned write, and the slave must decode the next address cleanly.

// File: rtl/twmPkg.sv
package twmPkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_WORD, ST_DATA, ST_WDONE, ST_TX, ST_SKIP, ST_BUSY
  } twmStateT;

  typedef struct packed {
    logic clrBit;
    logic incBit;
    logic shiftIn;
    logic loadWord;
    logic loadData;
    logic loadTx;
    logic shiftTx;
    logic commitWrite;
  } twmStrobeT;
endpackage

// File: rtl/twmDatapath.sv
module twmDatapath
  import twmPkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int ID_W        = 4,
  parameter logic [ID_W-1:0] DEV_ID = 4'b1010,
  parameter int PROT_LO     = 48,
  parameter int PROT_HI     = 55,
  parameter int BUSY_CYCLES = 2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [6-ID_W:0]   selPins,
  input  twmStrobeT         st,
  output logic              sclRise,
  output logic              sclFall,
  output logic              startSeen,
  output logic              stopSeen,
  output logic              sdaNow,
  output logic [3:0]        bitCnt,
  output logic [7:0]        rxByte,
  output logic              idMatch,
  output logic              protHit,
  output logic              memMsb,
  output logic              txNext,
  output logic              busyDone
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int SEL_W = 7 - ID_W;
  localparam int BCW   = $clog2(BUSY_CYCLES + 1);

  logic [2:0] sclSh, sdaSh;
  logic [7:0] rxShift, txShift, dataReg;
  logic [ADDR_W-1:0] wordAddr;
  logic [BCW-1:0] busyCnt;
  logic [7:0] memArr [DEPTH];

  // two-stage synchroniser plus one history stage for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclSh <= '1;
      sdaSh <= '1;
    end else begin
      sclSh <= {sclSh[1:0], sclIn};
      sdaSh <= {sdaSh[1:0], sdaIn};
    end
  end

  assign sdaNow    = sdaSh[1];
  assign sclRise   = sclSh[1] & ~sclSh[2];
  assign sclFall   = ~sclSh[1] & sclSh[2];
  assign startSeen = sclSh[1] & sclSh[2] & sdaSh[2] & ~sdaSh[1];
  assign stopSeen  = sclSh[1] & sclSh[2] & ~sdaSh[2] & sdaSh[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitCnt   <= '0;
      rxShift  <= '0;
      txShift  <= '0;
      dataReg  <= '0;
      wordAddr <= '0;
    end else begin
      if (st.clrBit)        bitCnt <= '0;
      else if (st.incBit)   bitCnt <= bitCnt + 4'd1;
      if (st.shiftIn)       rxShift <= {rxShift[6:0], sdaNow};
      if (st.loadData)      dataReg <= rxShift;
      if (st.loadWord)      wordAddr <= rxShift[ADDR_W-1:0];
      else if (st.loadTx)   wordAddr <= wordAddr + 1'b1;
      if (st.loadTx)        txShift <= memArr[wordAddr];
      else if (st.shiftTx)  txShift <= {txShift[6:0], 1'b0};
    end
  end

  // register-file array, one generated row per word
  for (genvar w = 0; w < DEPTH; w++) begin : gRow
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        memArr[w] <= '0;
      else if (st.commitWrite && wordAddr == ADDR_W'(w))
        memArr[w] <= dataReg;
    end
  end

  // write-busy timer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      busyCnt <= '0;
    else if (st.commitWrite)
      busyCnt <= BCW'(BUSY_CYCLES);
    else if (busyCnt != '0)
      busyCnt <= busyCnt - 1'b1;
  end

  assign busyDone = (busyCnt == BCW'(1));
  assign rxByte   = rxShift;
  assign idMatch  = (rxShift[7 -: ID_W] == DEV_ID) && (rxShift[SEL_W:1] == selPins);
  assign protHit  = (int'(wordAddr) >= PROT_LO) && (int'(wordAddr) <= PROT_HI);
  assign memMsb   = memArr[wordAddr][7];
  assign txNext   = txShift[6];
endmodule

// File: rtl/twmControl.sv
module twmControl
  import twmPkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startSeen,
  input  logic       stopSeen,
  input  logic       sdaNow,
  input  logic [3:0] bitCnt,
  input  logic       rxRw,
  input  logic       idMatch,
  input  logic       protHit,
  input  logic       memMsb,
  input  logic       txNext,
  input  logic       busyDone,
  output twmStrobeT  st,
  output logic       sdaLow,
  output logic       busyNow
);
  twmStateT state;
  logic ackOk, rwReg, mAck;
  logic rxState, live, ackNow, ackFall, endFall;

  assign rxState = (state == ST_DEV) || (state == ST_WORD) || (state == ST_DATA);
  assign live    = (state != ST_BUSY) && !startSeen && !stopSeen;
  assign ackFall = live && rxState && sclFall && (bitCnt == 4'd8);
  assign endFall = live && rxState && sclFall && (bitCnt == 4'd9);
  assign busyNow = (state == ST_BUSY);

  always_comb begin
    unique case (state)
      ST_DEV:  ackNow = idMatch;
      ST_WORD: ackNow = 1'b1;
      ST_DATA: ackNow = !protHit;
      default: ackNow = 1'b0;
    endcase
  end

  always_comb begin
    st = '0;
    st.commitWrite = stopSeen && (state == ST_WDONE);
    st.shiftIn  = live && rxState && sclRise && (bitCnt < 4'd8);
    st.loadWord = ackFall && (state == ST_WORD);
    st.loadData = ackFall && (state == ST_DATA) && ackNow;
    st.shiftTx  = live && (state == ST_TX) && sclFall && (bitCnt < 4'd7);
    st.loadTx   = (endFall && (state == ST_DEV) && ackOk && rwReg) ||
                  (live && (state == ST_TX) && sclFall && (bitCnt == 4'd9) && mAck);
    st.clrBit   = (startSeen && state != ST_BUSY) || endFall || st.loadTx;
    st.incBit   = st.shiftIn || ackFall ||
                  (live && (state == ST_TX) && sclFall && (bitCnt < 4'd8)) ||
                  (live && (state == ST_TX) && sclRise && (bitCnt == 4'd8));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      sdaLow <= 1'b0;
      ackOk  <= 1'b0;
      rwReg  <= 1'b0;
      mAck   <= 1'b0;
    end else if (state == ST_BUSY) begin
      if (busyDone) state <= ST_IDLE;
    end else if (startSeen) begin
      state  <= ST_DEV;
      sdaLow <= 1'b0;
    end else if (stopSeen) begin
      sdaLow <= 1'b0;
      state  <= (state == ST_WDONE) ? ST_BUSY : ST_IDLE;
    end else if (ackFall) begin
      sdaLow <= ackNow;
      ackOk  <= ackNow;
      if (state == ST_DEV) rwReg <= rxRw;
    end else if (endFall) begin
      sdaLow <= 1'b0;
      if (!ackOk)
        state <= ST_SKIP;
      else begin
        unique case (state)
          ST_DEV: begin
            if (rwReg) begin
              state  <= ST_TX;
              sdaLow <= !memMsb;
            end else
              state <= ST_WORD;
          end
          ST_WORD: state <= ST_DATA;
          default: state <= ST_WDONE;
        endcase
      end
    end else if (state == ST_TX) begin
      if (sclFall && bitCnt < 4'd7)
        sdaLow <= !txNext;
      else if (sclFall && bitCnt == 4'd7)
        sdaLow <= 1'b0;
      else if (sclRise && bitCnt == 4'd8)
        mAck <= !sdaNow;
      else if (sclFall && bitCnt == 4'd9) begin
        if (mAck)
          sdaLow <= !memMsb;
        else
          state <= ST_SKIP;
      end
    end
  end
endmodule

// File: rtl/twoWireMemSlave.sv
module twoWireMemSlave
  import twmPkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int ID_W        = 4,
  parameter logic [ID_W-1:0] DEV_ID = 4'b1010,
  parameter int PROT_LO     = 48,
  parameter int PROT_HI     = 55,
  parameter int BUSY_CYCLES = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] selPins,
  output logic       sdaDriveLow
);
  twmStrobeT  st;
  logic       sclRise, sclFall, startSeen, stopSeen, sdaNow;
  logic       idMatch, protHit, memMsb, txNext, busyDone, busyNow;
  logic [3:0] bitCnt;
  logic [7:0] rxByte;

  twmDatapath #(
    .ADDR_W(ADDR_W), .ID_W(ID_W), .DEV_ID(DEV_ID),
    .PROT_LO(PROT_LO), .PROT_HI(PROT_HI), .BUSY_CYCLES(BUSY_CYCLES)
  ) uData (
    .clk(clk), .rst_n(rst_n), .sclIn(sclIn), .sdaIn(sdaIn), .selPins(selPins),
    .st(st), .sclRise(sclRise), .sclFall(sclFall), .startSeen(startSeen),
    .stopSeen(stopSeen), .sdaNow(sdaNow), .bitCnt(bitCnt), .rxByte(rxByte),
    .idMatch(idMatch), .protHit(protHit), .memMsb(memMsb), .txNext(txNext),
    .busyDone(busyDone)
  );

  twmControl uCtrl (
    .clk(clk), .rst_n(rst_n), .sclRise(sclRise), .sclFall(sclFall),
    .startSeen(startSeen), .stopSeen(stopSeen), .sdaNow(sdaNow),
    .bitCnt(bitCnt), .rxRw(rxByte[0]), .idMatch(idMatch), .protHit(protHit),
    .memMsb(memMsb), .txNext(txNext), .busyDone(busyDone),
    .st(st), .sdaLow(sdaDriveLow), .busyNow(busyNow)
  );
endmodule

// File: rtl/twmChecker.sv
module twmChecker (
  input logic clk,
  input logic rst_n,
  input logic sdaDriveLow,
  input logic busyNow,
  input logic startSeen,
  input logic stopSeen,
  input logic sclFall
);
  // R6: released line for the whole busy period
  a_r6_quiet_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busyNow |-> !sdaDriveLow);

  // R5: busy period only ever begins right after a detected stop
  a_r5_busy_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busyNow) |-> $past(stopSeen));

  // R1: drive changes only after a falling bus clock, start or stop
  a_r1_drive_timing: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdaDriveLow) |-> $past(sclFall || startSeen || stopSeen));

  // R11: a start outside busy releases the line
  a_r11_start_release: assert property (@(posedge clk) disable iff (!rst_n)
    (startSeen && !busyNow) |=> !sdaDriveLow);

  // R11: a stop outside busy releases the line
  a_r11_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    (stopSeen && !busyNow) |=> !sdaDriveLow);
endmodule

bind twoWireMemSlave twmChecker uChk (
  .clk(clk), .rst_n(rst_n), .sdaDriveLow(sdaDriveLow), .busyNow(busyNow),
  .startSeen(startSeen), .stopSeen(stopSeen), .sclFall(sclFall)
);

// File: tb/twoWireMemSlave_test.sv
`timescale 1ns/1ps
module twoWireMemSlave_test;
  localparam int H     = 16;
  localparam int BUSY  = 400;
  localparam int DEPTH = 64;
  localparam logic [2:0] SEL = 3'b011;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sdaM = 1'b1;
  logic sdaDriveLow;
  logic sdaLine;
  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  bit expQuiet = 1'b0;
  logic [7:0] refMem [DEPTH];

  always #2.5 clk = ~clk;
  assign sdaLine = sdaM & ~sdaDriveLow;

  twoWireMemSlave #(.BUSY_CYCLES(BUSY)) uut (
    .clk(clk), .rst_n(rst_n), .sclIn(scl), .sdaIn(sdaLine),
    .selPins(SEL), .sdaDriveLow(sdaDriveLow)
  );

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison with the model's expectation of a silent slave
  always @(negedge clk) begin
    cyc++;
    if (rst_n && expQuiet) chk("R6/R8 quiet line", int'(sdaDriveLow), 0);
    if (cyc > 150000) begin
      mismatched++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; hold(H); scl = 1'b1; hold(H); sdaM = 1'b0; hold(H); scl = 1'b0; hold(2);
  endtask

  task automatic busStop();
    sdaM = 1'b0; hold(H); scl = 1'b1; hold(H); sdaM = 1'b1; hold(H);
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; hold(H); scl = 1'b1; hold(H); scl = 1'b0;
    end
    sdaM = 1'b1; hold(H); scl = 1'b1; hold(H / 2);
    acked = !sdaLine;
    hold(H / 2); scl = 1'b0; hold(2);
  endtask

  task automatic recvByte(input bit ackIt, output logic [7:0] b);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hold(H); scl = 1'b1; hold(H / 2); b[i] = sdaLine; hold(H / 2); scl = 1'b0;
    end
    hold(2); sdaM = !ackIt; hold(H); scl = 1'b1; hold(H); scl = 1'b0; hold(2); sdaM = 1'b1;
  endtask

  function automatic logic [7:0] devByte(input bit rd);
    return {4'b1010, SEL, rd};
  endfunction

  function automatic bit inProt(input int a);
    return (a >= 48) && (a <= 55);
  endfunction

  task automatic byteWrite(input int a, input logic [7:0] d);
    bit k;
    busStart();
    sendByte(devByte(0), k);  chk("R2 address ack (write)", int'(k), 1);
    sendByte(8'(a), k);       chk("R3 word address ack", int'(k), 1);
    sendByte(d, k);           chk("R3/R9 data ack", int'(k), inProt(a) ? 0 : 1);
    if (!inProt(a)) refMem[a] = d;
    busStop();
    expQuiet = 1'b1; hold(BUSY + 20); expQuiet = 1'b0;
  endtask

  task automatic seqRead(input int a, input int n);
    bit k;
    logic [7:0] got;
    busStart();
    sendByte(devByte(0), k);  chk("R11 address ack", int'(k), 1);
    sendByte(8'(a), k);       chk("R3 word address ack", int'(k), 1);
    busStart();
    sendByte(devByte(1), k);  chk("R7 read address ack", int'(k), 1);
    for (int i = 0; i < n; i++) begin
      recvByte(i != n - 1, got);
      chk("R7/R10 read data", int'(got), int'(refMem[(a + i) % DEPTH]));
    end
    expQuiet = 1'b1; hold(H); expQuiet = 1'b0;   // R8 released after master nack
    busStop();
  endtask

  initial begin
    bit k;
    logic [7:0] got;
    for (int i = 0; i < DEPTH; i++) refMem[i] = 8'h00;
    hold(5);
    chk("R12 reset release", int'(sdaDriveLow), 0);
    rst_n = 1'b1;
    hold(10);

    seqRead(0, 2);                       // R12 array cleared

    // R4 byte write, then R6 address during busy
    busStart();
    sendByte(devByte(0), k); chk("R2 address ack", int'(k), 1);
    sendByte(8'd5, k);       chk("R3 word ack", int'(k), 1);
    sendByte(8'h12, k);      chk("R3 data ack", int'(k), 1);
    refMem[5] = 8'h12;
    busStop();
    expQuiet = 1'b1;
    busStart();
    sendByte(devByte(1), k); chk("R6 no ack while busy", int'(k), 0);
    busStop();
    hold(BUSY);
    expQuiet = 1'b0;
    seqRead(5, 1);                       // R4 read-back

    // R2 wrong identifier and wrong select
    expQuiet = 1'b1;
    busStart();
    sendByte(8'hB6, k);      chk("R2 wrong id nack", int'(k), 0);
    sendByte(8'h00, k);      chk("R2 ignored byte", int'(k), 0);
    busStop();
    busStart();
    sendByte({4'b1010, SEL ^ 3'b001, 1'b0}, k); chk("R2 wrong select nack", int'(k), 0);
    busStop();
    expQuiet = 1'b0;

    // R9 protected write refused
    byteWrite(50, 8'h77);
    seqRead(50, 1);

    // R10 wrap at top
    byteWrite(63, 8'hC3);
    byteWrite(0, 8'h3C);
    byteWrite(1, 8'hA5);
    seqRead(63, 3);

    // R5 repeated start before stop abandons the write
    busStart();
    sendByte(devByte(0), k);
    sendByte(8'd9, k);
    sendByte(8'h99, k);      chk("R5 data ack", int'(k), 1);
    busStart();
    sendByte(devByte(1), k); chk("R5 no busy after repeated start", int'(k), 1);
    recvByte(1'b0, got);     chk("R5 word unchanged", int'(got), int'(refMem[9]));
    busStop();
    hold(H);

    // R11 stop inside a byte, then clean decode
    busStart();
    for (int i = 0; i < 4; i++) begin
      sdaM = 1'b1; hold(H); scl = 1'b1; hold(H); scl = 1'b0;
    end
    busStop();
    chk("R11 released after stray stop", int'(sdaDriveLow), 0);
    seqRead(5, 1);

    // R1 drive alternates with data pattern 0x55 MSB first
    byteWrite(20, 8'h55);
    seqRead(20, 1);

    hold(20);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule